// File: doc/BRIEF.md
# Protection-Unit Configuration Register Bank

This block is the register bank of a system control coprocessor that sets up a memory protection unit. The processor reaches it through coprocessor register-transfer operations. Each access carries a 4-bit register number, a 4-bit auxiliary index, a 3-bit secondary opcode, a read/write flag, 32 bits of write data and a privilege flag. The bank answers one cycle later with registered read data and a one-cycle undefined-instruction trap pulse.

The bank holds several registers:
- a read-only identification word;
- one shared control word;
- per-region cacheable masks;
- per-region bufferable masks;
- 2-bit per-region access permissions;
- a base/size/enable word for each region.

The secondary opcode picks the data-side or the instruction-side copy of the region registers. The auxiliary index picks one region word.

Every access that the bank cannot honour raises the trap and leaves all state as it was. This covers user-mode accesses, unimplemented register numbers, unknown unit selectors and out-of-range region indices.

Top module: `sccfg_regfile`

## Requirements
- R1: An access with `priv`=0 raises `undef_trap` in the following cycle, returns `rdata`=0 and changes no register.
- R2: An access traps (`undef_trap`=1 next cycle, `rdata`=0, no state change) in any of these cases: `reg_num` is not one of 0, 1, 2, 3, 5, 6; `sub_op` is greater than 1; or `reg_num`=6 with `aux_idx` of NUM_REGIONS or more.
- R3: `rdata` and `undef_trap` are registered and belong to the access presented one cycle earlier. Both are 0 after a cycle with no access. A write that does not trap returns `rdata`=0 and `undef_trap`=0.
- R4: A read of register 0 returns {IMPL[31:24], ARCH[23:16], PART[15:4], REV[3:0]} from the parameters. A write to register 0 does not trap and has no effect.
- R5: Register 1 is a single control word, shared by both `sub_op` values. Bit 0 enables protection, bit 2 the cache, bit 3 the write buffer and bit 7 big-endian ordering. Only these bits can be written; all other bits read 0.
- R6: Register 2 holds the cacheable mask, with bit n for region n. Bits above NUM_REGIONS-1 read 0.
- R7: Register 3 holds the bufferable mask, with bit n for region n, on the data side (`sub_op`=0) only. The instruction-side copy always reads 0, and writes to it are ignored without a trap.
- R8: Register 5 holds the permissions of region n in bits [2n+1:2n]: 00 no access, 01 privileged only, 10 privileged full with user read-only, 11 full access. Unused upper bits read 0.
- R9: Register 6 addresses region `aux_idx`. Its word holds base [31:12], size code [5:1] and enable [0]; bits [11:6] read 0.
- R10: After reset every stored register reads 0.
- R11: `sub_op`=0 (data side) and `sub_op`=1 (instruction side) address independent copies of registers 2, 3, 5 and 6. A write to one copy never shows in the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register-transfer strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| reg_num | input | 4 | Register number |
| aux_idx | input | 4 | Auxiliary index (region for register 6) |
| sub_op | input | 3 | Secondary opcode: 0 data side, 1 instruction side |
| priv | input | 1 | 1 = privileged mode |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after the strobe |
| undef_trap | output | 1 | Undefined-instruction trap pulse |

## Verification
The assertions check several properties on every cycle:
- the response to each access shape: user-mode and unimplemented-register traps, idle and write cycles returning zero;
- the constant identification word;
- the zero bits that register 1, the instruction-side buffer mask and the region words must always show.

Other behaviour can only be shown by the bench's scenarios, which write and read back through the ports:
- values stored and then read back;
- the independence of the two unit copies;
- the claim that trapped or ignored writes left the state untouched;
- region indexing across all eight words.

// File: rtl/sccfg_pkg.sv
package sccfg_pkg;

    localparam int WORD_W = 32;
    localparam int REGNUM_W = 4;
    localparam int SUBOP_W = 3;

    localparam logic [WORD_W-1:0] CTRL_WR_MASK = 32'h0000_008D;
    localparam logic [WORD_W-1:0] RGN_WR_MASK = 32'hFFFF_F03F;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_ID,
        TGT_CTRL,
        TGT_CACHE,
        TGT_BUFF,
        TGT_PERM,
        TGT_REGION
    } target_e;

    typedef struct packed {
        logic    valid;
        logic    write;
        logic    trap;
        logic    side;
        target_e target;
    } dec_t;

endpackage

// File: rtl/sccfg_decode.sv
module sccfg_decode
    import sccfg_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W = 3
) (
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic                priv,
    input  logic [REGNUM_W-1:0] reg_num,
    input  logic [3:0]          aux_idx,
    input  logic [SUBOP_W-1:0]  sub_op,
    output dec_t                dec,
    output logic [IDX_W-1:0]    rgn_idx
);

    target_e tgt;
    logic    bad_unit;
    logic    bad_index;

    always_comb begin
        case (reg_num)
            4'd0:    tgt = TGT_ID;
            4'd1:    tgt = TGT_CTRL;
            4'd2:    tgt = TGT_CACHE;
            4'd3:    tgt = TGT_BUFF;
            4'd5:    tgt = TGT_PERM;
            4'd6:    tgt = TGT_REGION;
            default: tgt = TGT_NONE;
        endcase
    end

    assign bad_unit  = (sub_op[SUBOP_W-1:1] != '0);
    assign bad_index = (tgt == TGT_REGION) && (32'(aux_idx) >= 32'(NUM_REGIONS));

    always_comb begin
        dec.valid  = acc_valid;
        dec.write  = acc_write;
        dec.side   = sub_op[0];
        dec.target = tgt;
        dec.trap   = acc_valid && (!priv || (tgt == TGT_NONE) || bad_unit || bad_index);
    end

    assign rgn_idx = aux_idx[IDX_W-1:0];

endmodule

// File: rtl/sccfg_unit_bank.sv
module sccfg_unit_bank
    import sccfg_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W = 3,
    parameter bit HAS_BUFFER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  target_e           target,
    input  logic [IDX_W-1:0]  rgn_idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_word
);

    localparam int PERM_W = 2 * NUM_REGIONS;

    typedef struct packed {
        logic [NUM_REGIONS-1:0]             cach;
        logic [NUM_REGIONS-1:0]             buff;
        logic [PERM_W-1:0]                  perm;
        logic [NUM_REGIONS-1:0][WORD_W-1:0] rgn;
    } bank_t;

    bank_t st_d, st_q;
    logic  buff_allow;

    generate
        if (HAS_BUFFER) begin : g_buff_on
            assign buff_allow = 1'b1;
        end else begin : g_buff_off
            assign buff_allow = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (target)
                TGT_CACHE:  st_d.cach = wdata[NUM_REGIONS-1:0];
                TGT_BUFF:   if (buff_allow) st_d.buff = wdata[NUM_REGIONS-1:0];
                TGT_PERM:   st_d.perm = wdata[PERM_W-1:0];
                TGT_REGION: st_d.rgn[rgn_idx] = wdata & RGN_WR_MASK;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_word = '0;
        case (target)
            TGT_CACHE:  rd_word[NUM_REGIONS-1:0] = st_q.cach;
            TGT_BUFF:   rd_word[NUM_REGIONS-1:0] = st_q.buff;
            TGT_PERM:   rd_word[PERM_W-1:0] = st_q.perm;
            TGT_REGION: rd_word = st_q.rgn[rgn_idx];
            default:    rd_word = '0;
        endcase
    end

endmodule

// File: rtl/sccfg_regfile.sv
module sccfg_regfile
    import sccfg_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter logic [7:0]  ID_IMPL = 8'h5A,
    parameter logic [7:0]  ID_ARCH = 8'h02,
    parameter logic [11:0] ID_PART = 12'h317,
    parameter logic [3:0]  ID_REV  = 4'h1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [REGNUM_W-1:0] reg_num,
    input  logic [3:0]          aux_idx,
    input  logic [SUBOP_W-1:0]  sub_op,
    input  logic                priv,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    output logic                undef_trap
);

    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
    localparam int NUM_UNITS = 2;
    localparam logic [WORD_W-1:0] ID_WORD = {ID_IMPL, ID_ARCH, ID_PART, ID_REV};

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] rdata;
        logic              trap;
    } top_t;

    dec_t              dec;
    logic [IDX_W-1:0]  rgn_idx;
    logic              wr_ok;
    logic [WORD_W-1:0] bank_rd [NUM_UNITS];
    top_t              s_d, s_q;

    sccfg_decode #(
        .NUM_REGIONS(NUM_REGIONS),
        .IDX_W(IDX_W)
    ) u_decode (
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .priv(priv),
        .reg_num(reg_num),
        .aux_idx(aux_idx),
        .sub_op(sub_op),
        .dec(dec),
        .rgn_idx(rgn_idx)
    );

    assign wr_ok = dec.valid && !dec.trap && dec.write;

    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            sccfg_unit_bank #(
                .NUM_REGIONS(NUM_REGIONS),
                .IDX_W(IDX_W),
                .HAS_BUFFER(u == 0)
            ) u_bank (
                .clk(clk),
                .rst_n(rst_n),
                .wr_en(wr_ok && (dec.side == 1'(u))),
                .target(dec.target),
                .rgn_idx(rgn_idx),
                .wdata(wdata),
                .rd_word(bank_rd[u])
            );
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        s_d.trap  = dec.trap;
        s_d.rdata = '0;
        if (wr_ok && dec.target == TGT_CTRL) begin
            s_d.ctrl = wdata & CTRL_WR_MASK;
        end
        if (dec.valid && !dec.trap && !dec.write) begin
            case (dec.target)
                TGT_ID:   s_d.rdata = ID_WORD;
                TGT_CTRL: s_d.rdata = s_q.ctrl;
                default:  s_d.rdata = bank_rd[dec.side];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata      = s_q.rdata;
    assign undef_trap = s_q.trap;

endmodule

// File: rtl/sccfg_checker.sv
module sccfg_checker #(
    parameter logic [31:0] ID_WORD = 32'h0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [3:0]  reg_num,
    input logic [2:0]  sub_op,
    input logic        priv,
    input logic [31:0] rdata,
    input logic        undef_trap
);

    logic good_read;
    assign good_read = acc_valid && !acc_write && priv && (sub_op <= 3'd1);

    assert_user_trap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !priv |=> undef_trap && rdata == 32'h0);

    assert_unused_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !(reg_num inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd6})
        |=> undef_trap && rdata == 32'h0);

    assert_bad_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && sub_op > 3'd1 |=> undef_trap);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !undef_trap && rdata == 32'h0);

    assert_write_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write |=> rdata == 32'h0);

    assert_id_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        good_read && reg_num == 4'd0 |=> rdata == ID_WORD && !undef_trap);

    assert_ctrl_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        good_read && reg_num == 4'd1 |=> (rdata & ~32'h0000_008D) == 32'h0);

    assert_ibuff_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        good_read && reg_num == 4'd3 && sub_op == 3'd1 |=> rdata == 32'h0);

    assert_rgn_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        good_read && reg_num == 4'd6 |=> rdata[11:6] == 6'h0);

endmodule

bind sccfg_regfile sccfg_checker #(.ID_WORD(ID_WORD)) u_checker (
    .clk(clk),
    .rst_n(rst_n),
    .acc_valid(acc_valid),
    .acc_write(acc_write),
    .reg_num(reg_num),
    .sub_op(sub_op),
    .priv(priv),
    .rdata(rdata),
    .undef_trap(undef_trap)
);

// File: tb/sccfg_regfile_test.sv
module sccfg_regfile_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] EXP_ID = 32'h5A02_3171;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  reg_num = '0;
    logic [3:0]  aux_idx = '0;
    logic [2:0]  sub_op = '0;
    logic        priv = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        undef_trap;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    bit started = 1'b0;

    string       cur_tag = "R3 idle";
    string       exp_tag = "R10 reset";
    logic [31:0] exp_rd = '0;
    logic        exp_trap = 1'b0;

    logic [31:0] m_ctrl;
    logic [7:0]  m_cach [2];
    logic [7:0]  m_buf;
    logic [15:0] m_perm [2];
    logic [31:0] m_rgn [2][8];

    always #(CLK_PERIOD/2) clk = ~clk;

    sccfg_regfile uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .reg_num(reg_num), .aux_idx(aux_idx), .sub_op(sub_op), .priv(priv),
        .wdata(wdata), .rdata(rdata), .undef_trap(undef_trap)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_buf = 0;
            for (int u = 0; u < 2; u++) begin
                m_cach[u] = 0; m_perm[u] = 0;
                for (int r = 0; r < 8; r++) m_rgn[u][r] = 0;
            end
            exp_rd <= 0; exp_trap <= 0;
        end else begin
            exp_tag <= cur_tag;
            if (!acc_valid) begin
                exp_rd <= 0; exp_trap <= 0;
            end else if (!priv || !(reg_num inside {0, 1, 2, 3, 5, 6}) || sub_op > 1
                         || (reg_num == 6 && aux_idx > 7)) begin
                exp_rd <= 0; exp_trap <= 1;
            end else begin
                automatic int s = sub_op;
                exp_trap <= 0;
                if (acc_write) begin
                    exp_rd <= 0;
                    case (reg_num)
                        1: m_ctrl = wdata & 32'h8D;
                        2: m_cach[s] = wdata[7:0];
                        3: if (s == 0) m_buf = wdata[7:0];
                        5: m_perm[s] = wdata[15:0];
                        6: m_rgn[s][aux_idx] = wdata & 32'hFFFFF03F;
                        default: ;
                    endcase
                end else begin
                    case (reg_num)
                        0: exp_rd <= EXP_ID;
                        1: exp_rd <= m_ctrl;
                        2: exp_rd <= {24'h0, m_cach[s]};
                        3: exp_rd <= (s == 0) ? {24'h0, m_buf} : 32'h0;
                        5: exp_rd <= {16'h0, m_perm[s]};
                        default: exp_rd <= m_rgn[s][aux_idx];
                    endcase
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            tests++;
            if (rdata !== exp_rd || undef_trap !== exp_trap) begin
                fails++;
                $display("FAIL %s: rdata=%h trap=%b expected rdata=%h trap=%b",
                         exp_tag, rdata, undef_trap, exp_rd, exp_trap);
            end
        end
    end

    task automatic acc(input string tag, input bit wr, input int rn, input int ax,
                       input int so, input bit pv, input logic [31:0] wd);
        @(negedge clk);
        cur_tag = tag;
        acc_valid = 1'b1; acc_write = wr; reg_num = 4'(rn); aux_idx = 4'(ax);
        sub_op = 3'(so); priv = pv; wdata = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cur_tag = "R3 idle";
            acc_valid = 1'b0; acc_write = 1'b0; wdata = '0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        started = 1'b1;
        // R10 reset state of every register
        acc("R10 ctrl", 0, 1, 0, 0, 1, 0);
        acc("R10 cache", 0, 2, 0, 1, 1, 0);
        acc("R10 perm", 0, 5, 0, 0, 1, 0);
        for (int r = 0; r < 8; r++) acc("R10 region", 0, 6, r, r % 2, 1, 0);
        // R4 identity and ignored write
        acc("R4 id", 0, 0, 0, 0, 1, 0);
        acc("R4 id write", 1, 0, 0, 0, 1, 32'hFFFF_FFFF);
        acc("R4 id after write", 0, 0, 0, 1, 1, 0);
        // R5 control word
        acc("R5 ctrl write", 1, 1, 0, 0, 1, 32'hFFFF_FFFF);
        acc("R5 ctrl mask", 0, 1, 0, 1, 1, 0);
        acc("R5 ctrl write", 1, 1, 0, 1, 1, 32'h0000_0085);
        acc("R5 ctrl M/B", 0, 1, 0, 0, 1, 0);
        // R6 / R11 cacheable masks
        acc("R6 cache d", 1, 2, 0, 0, 1, 32'hFFFF_FFA5);
        acc("R6 cache i", 1, 2, 0, 1, 1, 32'h0000_003C);
        acc("R11 cache d", 0, 2, 0, 0, 1, 0);
        acc("R11 cache i", 0, 2, 0, 1, 1, 0);
        // R7 bufferable masks
        acc("R7 buff d", 1, 3, 0, 0, 1, 32'h0000_00F1);
        acc("R7 buff i", 1, 3, 0, 1, 1, 32'h0000_00FF);
        acc("R7 buff d read", 0, 3, 0, 0, 1, 0);
        acc("R7 buff i read", 0, 3, 0, 1, 1, 0);
        // R8 permissions with all four codes
        acc("R8 perm d", 1, 5, 0, 0, 1, 32'hABCD_E4E4);
        acc("R8 perm i", 1, 5, 0, 1, 1, 32'h0000_1B00);
        acc("R8 perm d read", 0, 5, 0, 0, 1, 0);
        acc("R11 perm i read", 0, 5, 0, 1, 1, 0);
        // R9 / R11 region words
        for (int r = 0; r < 8; r++) begin
            acc("R9 rgn d write", 1, 6, r, 0, 1, 32'h1000_0FFF + (r << 20));
            acc("R9 rgn i write", 1, 6, r, 1, 1, 32'h8000_0017 + (r << 12));
        end
        for (int r = 0; r < 8; r++) begin
            acc("R9 rgn d read", 0, 6, r, 0, 1, 0);
            acc("R11 rgn i read", 0, 6, r, 1, 1, 0);
        end
        idle(2);
        // R1 user mode traps, state untouched
        acc("R1 user write", 1, 1, 0, 0, 0, 32'h0);
        acc("R1 user read", 0, 0, 0, 0, 0, 0);
        acc("R1 user rgn", 1, 6, 3, 0, 0, 32'h0);
        acc("R1 ctrl kept", 0, 1, 0, 0, 1, 0);
        acc("R1 rgn kept", 0, 6, 3, 0, 1, 0);
        // R2 unimplemented registers, bad unit, bad index
        for (int n = 4; n < 16; n++) if (n != 5 && n != 6) acc("R2 unused reg", n % 2, n, 0, 0, 1, 32'hFFFF_FFFF);
        acc("R2 bad unit", 1, 2, 0, 2, 1, 32'h0);
        acc("R2 bad unit", 0, 1, 0, 7, 1, 0);
        acc("R2 bad index", 1, 6, 8, 0, 1, 32'h0);
        acc("R2 bad index", 0, 6, 15, 1, 1, 0);
        acc("R2 cache kept", 0, 2, 0, 0, 1, 0);
        // R3 back-to-back with idle gaps
        idle(1);
        acc("R3 read", 0, 5, 0, 1, 1, 0);
        idle(1);
        acc("R3 write", 1, 5, 0, 1, 1, 32'h0000_FFFF);
        acc("R3 read after write", 0, 5, 0, 1, 1, 0);
        idle(2);
        // R10 reset in mid-run clears storage
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        acc("R10 ctrl after reset", 0, 1, 0, 0, 1, 0);
        acc("R10 rgn after reset", 0, 6, 0, 0, 1, 0);
        acc("R10 buff after reset", 0, 3, 0, 0, 1, 0);
        idle(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule